// File: doc/BRIEF.md
# Change-of-State Input Interrupt Unit

This block samples a 32-bit bank of digital inputs and raises an interrupt request when selected inputs change in a chosen way. Only channels 4 through 19 can be armed. Two per-channel select masks name the channels that react to a high input and the channels that react to a low input. A two-bit logic field chooses how the selected channels combine. In OR mode any single selected edge fires. In AND mode the request fires when every selected channel sits at its level in the same cycle.

When the request fires, the block captures the interrupt-capable slice of the inputs into a status word and holds the request until software clears it. Software clears it by writing the control register with the enable bit low and then writing back the value it read. All registers sit behind a plain 32-bit word interface with a single-cycle write strobe and a combinational read port.

Top module: `cos_irq_unit`

## Requirements
- R1: After reset the rise select (0x04), fall select (0x08), status (0x0C) and control (0x10) registers read 0, and `irq` is low.
- R2: Offset 0x00 reads all 32 inputs through a two-flop synchroniser. An input change made before a clock edge appears on the read port after the second edge.
- R3: Writes to the select registers keep only bits 19:4. Writing 0xFFFFFFFF reads back 0x000FFFF0.
- R4: With control bits[1:0]=01 (OR logic), a rising edge on a channel set in the rise select, or a falling edge on a channel set in the fall select, sets `irq`. The request appears after the third clock edge following the input change.
- R5: Edges on channels that neither select register names, including bits 3:0 and 31:20, raise no request and leave the status word unchanged.
- R6: With control bit 1 set (AND logic, which wins over bit 0), the request fires once, when every rise-selected channel is high and every fall-selected channel is low in the same cycle. It fires again only after that condition has gone false and then true again.
- R7: When a request fires, the status register captures inputs 19:4 (all other bits 0) and holds that value until the next request.
- R8: Control bit 2, when written 1, enables requests. On read, bit 2 returns 1 only while a request is pending, and bits[1:0] return the logic field. `irq` equals the pending flag.
- R9: Writing the control register with bit 2 low clears the pending request after that edge and disables the unit. Writing the original value back re-enables the unit without raising a request.
- R10: No request is raised while bit 2 is 0, while the logic field is 00, or while both select registers are 0.
- R11: If a control write with bit 2 low lands in the same cycle as a qualifying event, the clear wins. `irq` stays low and the status word is not updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 32 | Asynchronous digital inputs |
| reg_addr | input | 5 | Byte address of the register word |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request, high while pending |

## Verification
Two functions can fall in the same cycle: the first half of the software clear handshake, and the detection of a qualifying input edge. The bench provokes this by changing a selected input and then timing the disabling control write so that it reaches the same clock edge at which the synchronised edge would set the request. It judges the result at the ports. `irq` must stay low, the control read must show bit 2 clear, and the status word must keep its earlier value. The restoring write that follows must also leave `irq` low.

// File: rtl/cos_pkg.sv
package cos_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_INPUT = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_RISE  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_FALL  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h10;

    localparam int CTRL_EN_BIT = 2;

    typedef enum logic [1:0] {
        LOGIC_OFF  = 2'b00,
        LOGIC_OR   = 2'b01,
        LOGIC_AND  = 2'b10,
        LOGIC_AND2 = 2'b11
    } logic_mode_e;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (!rst_n) stg_q[i] <= '0;
            else        stg_q[i] <= stg_d[i];
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/cos_detect.sv
module cos_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp,
    input  logic [W-1:0] rise_sel,
    input  logic [W-1:0] fall_sel,
    input  logic         or_mode,
    input  logic         and_mode,
    output logic         event_o
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic         cond;
    } det_t;

    det_t         st_d, st_q;
    logic [W-1:0] edges;
    logic         any_sel;
    logic         lvl;

    always_comb begin
        edges   = (smp & ~st_q.prev & rise_sel) | (~smp & st_q.prev & fall_sel);
        any_sel = |(rise_sel | fall_sel);
        lvl     = any_sel
                  && ((smp & rise_sel) == rise_sel)
                  && ((~smp & fall_sel) == fall_sel);
        st_d.prev = smp;
        st_d.cond = lvl;
        if (and_mode)     event_o = lvl && !st_q.cond;
        else if (or_mode) event_o = |edges;
        else              event_o = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: a level event cannot repeat on the next cycle
    a_r6_and_single: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && and_mode) |=> !(event_o && and_mode));

    // R10: with no channel selected nothing fires
    a_r10_no_sel_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_sel == '0 && fall_sel == '0) |-> !event_o);

    // R5: an OR event needs some input to have moved
    a_r5_or_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && !and_mode) |-> (smp != st_q.prev));
endmodule

// File: rtl/cos_irq_unit.sv
module cos_irq_unit
    import cos_pkg::*;
#(
    parameter int LO_CH       = 4,
    parameter int HI_CH       = 19,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam logic [DATA_W-1:0] INT_MASK =
        ({DATA_W{1'b1}} >> (DATA_W - 1 - HI_CH)) & ({DATA_W{1'b1}} << LO_CH);

    typedef struct packed {
        logic [DATA_W-1:0] rise_sel;
        logic [DATA_W-1:0] fall_sel;
        logic [DATA_W-1:0] stat;
        logic_mode_e       mode;
        logic              en;
        logic              pend;
    } unit_t;

    unit_t             st_d, st_q;
    logic [DATA_W-1:0] smp;
    logic              ev;
    logic              wr_rise, wr_fall, wr_ctrl;

    cos_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (din),
        .sync_o  (smp)
    );

    cos_detect #(.W(DATA_W)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp      (smp),
        .rise_sel (st_q.rise_sel),
        .fall_sel (st_q.fall_sel),
        .or_mode  (st_q.mode == LOGIC_OR),
        .and_mode (st_q.mode[1]),
        .event_o  (ev)
    );

    always_comb begin
        st_d    = st_q;
        wr_rise = reg_wr && (reg_addr == OFS_RISE);
        wr_fall = reg_wr && (reg_addr == OFS_FALL);
        wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);

        if (wr_rise) st_d.rise_sel = reg_wdata & INT_MASK;
        if (wr_fall) st_d.fall_sel = reg_wdata & INT_MASK;
        if (wr_ctrl) begin
            st_d.mode = logic_mode_e'(reg_wdata[1:0]);
            st_d.en   = reg_wdata[CTRL_EN_BIT];
            if (!reg_wdata[CTRL_EN_BIT]) st_d.pend = 1'b0;
        end
        if (ev && st_d.en) begin
            st_d.pend = 1'b1;
            st_d.stat = smp & INT_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_addr)
            OFS_INPUT: reg_rdata = smp;
            OFS_RISE:  reg_rdata = st_q.rise_sel;
            OFS_FALL:  reg_rdata = st_q.fall_sel;
            OFS_STAT:  reg_rdata = st_q.stat;
            OFS_CTRL:  reg_rdata = {{(DATA_W-3){1'b0}}, st_q.pend, st_q.mode};
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = st_q.pend;

    // R8: a pending request implies the unit is enabled
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> st_q.en);

    // R7: captured status never holds bits outside the capable range
    a_r7_stat_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stat & ~INT_MASK) == '0);

    // R9: a disabling control write drops the request
    a_r9_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CTRL && !reg_wdata[CTRL_EN_BIT]) |=> !irq);

    // R4: a new request is always caused by a detected event
    a_r4_rise_from_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ev));
endmodule

// File: tb/tb_cos_irq_unit.sv
module tb_cos_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] din = '0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [31:0] exp_stat = '0;

    always #10 clk = ~clk;

    cos_irq_unit dut (
        .clk(clk), .rst_n(rst_n), .din(din), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic drive(input logic [31:0] v);
        @(negedge clk);
        din = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_irq(input logic [31:0] ctrl_val, input string tag);
        wr(5'h10, ctrl_val & ~32'h4);
        check({tag, " clear"}, {31'b0, irq}, 32'h0);
        wr(5'h10, ctrl_val);
        check({tag, " restore"}, {31'b0, irq}, 32'h0);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(5'h04, v); check("R1 rise sel", v, 0);
        rd(5'h08, v); check("R1 fall sel", v, 0);
        rd(5'h0C, v); check("R1 status", v, 0);
        rd(5'h10, v); check("R1 ctrl", v, 0);
        check("R1 irq", {31'b0, irq}, 0);
    endtask

    task automatic t_input;
        logic [31:0] v;
        @(negedge clk);
        din = 32'hA5A5_1234;
        @(negedge clk);
        rd(5'h00, v); check("R2 one edge", v, 32'h0);
        @(negedge clk);
        rd(5'h00, v); check("R2 two edges", v, 32'hA5A5_1234);
        drive(32'h0);
    endtask

    task automatic t_masks;
        logic [31:0] v;
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h04, v); check("R3 rise mask", v, 32'h000F_FFF0);
        wr(5'h08, 32'hFFFF_FFFF);
        rd(5'h08, v); check("R3 fall mask", v, 32'h000F_FFF0);
        wr(5'h04, 0); wr(5'h08, 0);
    endtask

    task automatic t_or;
        logic [31:0] v;
        wr(5'h04, 32'h10); wr(5'h08, 32'h8_0000); wr(5'h10, 32'h5);
        rd(5'h10, v); check("R8 enabled idle reads bit2 low", v, 32'h1);
        drive(32'h8000_0310);
        exp_stat = 32'h310;
        check("R4 rise fires", {31'b0, irq}, 1);
        rd(5'h10, v); check("R8 pending bit", v, 32'h5);
        rd(5'h0C, v); check("R7 status capture", v, exp_stat);
        clear_irq(32'h5, "R9 or");
        drive(32'h8008_0310);
        check("R5 rise on fall-only channel", {31'b0, irq}, 0);
        drive(32'h8000_0210);
        exp_stat = 32'h210;
        check("R4 fall fires", {31'b0, irq}, 1);
        rd(5'h0C, v); check("R7 status second capture", v, exp_stat);
        clear_irq(32'h5, "R9 or2");
    endtask

    task automatic t_unsel;
        logic [31:0] v;
        drive(32'h8000_0210 ^ 32'h0200_0401);
        check("R5 unselected edges", {31'b0, irq}, 0);
        rd(5'h0C, v); check("R5 status unchanged", v, exp_stat);
    endtask

    task automatic t_and;
        logic [31:0] v;
        wr(5'h10, 32'h0);
        drive(32'h0);
        wr(5'h04, 32'h60); wr(5'h08, 32'h80); wr(5'h10, 32'h6);
        drive(32'h20);
        check("R6 partial no fire", {31'b0, irq}, 0);
        drive(32'h60);
        exp_stat = 32'h60;
        check("R6 full condition fires", {31'b0, irq}, 1);
        rd(5'h0C, v); check("R7 and status", v, exp_stat);
        clear_irq(32'h6, "R9 and");
        repeat (5) @(negedge clk);
        check("R6 no refire while held", {31'b0, irq}, 0);
        drive(32'h160);
        check("R6 unrelated change", {31'b0, irq}, 0);
        drive(32'h10E0);
        check("R6 fall channel high", {31'b0, irq}, 0);
        drive(32'h1060);
        exp_stat = 32'h1060;
        check("R6 re-entry fires", {31'b0, irq}, 1);
        rd(5'h0C, v); check("R7 re-entry status", v, exp_stat);
        clear_irq(32'h6, "R9 and2");
    endtask

    task automatic t_disabled;
        wr(5'h10, 32'h0);
        drive(32'h0);
        wr(5'h04, 32'h10); wr(5'h08, 32'h0); wr(5'h10, 32'h4);
        drive(32'h10);
        check("R10 logic off", {31'b0, irq}, 0);
        drive(32'h0);
        wr(5'h04, 32'h0); wr(5'h10, 32'h5);
        drive(32'h10);
        check("R10 empty masks", {31'b0, irq}, 0);
        drive(32'h0);
        wr(5'h04, 32'h10); wr(5'h10, 32'h1);
        drive(32'h10);
        check("R10 enable low", {31'b0, irq}, 0);
        drive(32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        wr(5'h04, 32'h10); wr(5'h10, 32'h5);
        @(negedge clk); din = 32'h0001_0010;
        @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 5'h10; reg_wdata = 32'h1;
        @(negedge clk);
        reg_wr = 1'b0;
        check("R11 clear wins", {31'b0, irq}, 0);
        rd(5'h10, v); check("R11 ctrl read", v, 32'h1);
        rd(5'h0C, v); check("R11 status kept", v, exp_stat);
        wr(5'h10, 32'h5);
        check("R11 restore no irq", {31'b0, irq}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_input;
        t_masks;
        t_or;
        t_unsel;
        t_and;
        t_disabled;
        t_collide;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule